// File: doc/BRIEF.md
# Digital Line Event Waiter

This block watches a single asynchronous digital line and tells its client when a chosen condition shows up on that line: a rising transition, a falling transition, a transition in either direction, a high level or a low level. The client issues one wait at a time. It raises `start` for a cycle and presents a condition code and a signed cycle budget. The block then reports completion with a single-cycle `done` pulse. A companion flag says whether the wait ended because the budget ran out.

The sign of the budget picks one of three behaviours. Zero finishes the request immediately as a timeout. A positive value N bounds the wait to N clock cycles. A negative value removes the bound, so the wait ends only when the condition occurs. The line passes through a synchronizer chain before any decision is made. Transitions are found by comparing consecutive synchronized samples.

Top module: `line_event_waiter`

## Requirements
- R1: `waitSel` selects the condition: 0 rising transition, 1 falling transition, 2 either transition, 3 line high, 4 line low. Codes 5 to 7 never match, so such a wait ends only by timeout.
- R2: A start accepted with `budget` equal to 0 produces `done` with `timedOut` high in the cycle right after the accepting edge, whatever the line does. `busy` stays low.
- R3: A start accepted with a positive `budget` N raises `busy` from the accepting edge. If the condition is not met, `done` with `timedOut` high comes exactly N clock edges after the accepting edge.
- R4: A start accepted with a negative `budget` never times out. It ends only when the condition is met, however long that takes.
- R5: Edge conditions respond only to a change of the synchronized sample that happens at the accepting edge or later. A transition that settled before the start is ignored.
- R6: In the level conditions with a nonzero budget, if the line already sits at the requested level, `done` with `timedOut` low comes on the first edge after the accepting edge.
- R7: A change of `lineIn` first captured at clock edge E is acted on so that `done` (with `timedOut` low) is registered at edge E+2, provided the wait is still open at that edge.
- R8: When the condition is met on the same evaluated cycle in which the budget runs out, the condition wins: `done` comes with `timedOut` low.
- R9: `done` lasts exactly one cycle and `busy` is low while it is high. `timedOut` is high only together with `done`.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running wait keeps its condition and budget.
- R11: Synchronous reset `rst` returns the block to idle with `busy`, `done` and `timedOut` low, including in the middle of a wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the unit of the budget |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin a wait |
| waitSel | input | 3 | Condition code, sampled with `start` |
| budget | input | 32 | Signed cycle budget, sampled with `start` |
| lineIn | input | 1 | Asynchronous line being watched |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | With `done`: the wait ended by budget expiry |

## Verification
Two events can land on the same evaluated cycle: the condition being met and the budget running out. The stimulus places a transition on `lineIn` so that its detection falls on the very last allowed edge of a positive budget (transition at offset 3 with budget 6). In that case the result must be a success. The same transition one cycle later, against a budget of 5, must give a timeout at edge 5. Both cases are judged by the cycle in which `done` appears and by the `timedOut` value that comes with it.

// File: rtl/evw_pkg.sv
package evw_pkg;

  typedef enum logic [2:0] {
    WAIT_RISE = 3'd0,
    WAIT_FALL = 3'd1,
    WAIT_ANY  = 3'd2,
    WAIT_HIGH = 3'd3,
    WAIT_LOW  = 3'd4
  } waitMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture condition and budget
    logic step;  // consume one cycle of budget
  } dpCmd_t;

endpackage

// File: rtl/evw_datapath.sv
module evw_datapath
  import evw_pkg::*;
#(
  parameter int TMO_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCmd_t           cmd,
  input  logic [2:0]       waitSel,
  input  logic [TMO_W-1:0] budget,
  input  logic             lineIn,
  output logic             condMet,
  output logic             lastTick,
  output logic             tmoZero,
  output logic             unbounded
);
  localparam int CNT_W = TMO_W - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncQ;
  logic                   prevQ;
  logic [2:0]             modeQ;
  logic [CNT_W-1:0]       remQ;
  logic                   infQ;

  // synchronizer chain, depth chosen by parameter
  always_ff @(posedge clk) begin
    if (rst) syncChain[0] <= 1'b0;
    else     syncChain[0] <= lineIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) syncChain[s] <= 1'b0;
      else     syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncQ = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= syncQ;
  end

  // request registers and budget counter
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= 3'd0;
      remQ  <= '0;
      infQ  <= 1'b0;
    end else if (cmd.load) begin
      modeQ <= waitSel;
      remQ  <= budget[CNT_W-1:0];
      infQ  <= budget[TMO_W-1];
    end else if (cmd.step && !infQ) begin
      remQ <= remQ - 1'b1;
    end
  end

  logic riseSeen, fallSeen;
  assign riseSeen = syncQ && !prevQ;
  assign fallSeen = !syncQ && prevQ;

  always_comb begin
    case (modeQ)
      WAIT_RISE: condMet = riseSeen;
      WAIT_FALL: condMet = fallSeen;
      WAIT_ANY:  condMet = riseSeen || fallSeen;
      WAIT_HIGH: condMet = syncQ;
      WAIT_LOW:  condMet = !syncQ;
      default:   condMet = 1'b0;
    endcase
  end

  assign lastTick  = !infQ && (remQ == CNT_W'(1));
  assign tmoZero   = (budget == '0);
  assign unbounded = infQ;

  // a step is only requested while budget remains above the final cycle
  p_step_above_last_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd.step && !infQ) |-> (remQ > CNT_W'(1)));

endmodule

// File: rtl/evw_ctrl.sv
module evw_ctrl
  import evw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   condMet,
  input  logic   lastTick,
  input  logic   tmoZero,
  input  logic   unbounded,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   done,
  output logic   timedOut
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e stateQ;

  assign busy = (stateQ == ST_WAIT);

  always_comb begin
    cmd.load = (stateQ == ST_IDLE) && start;
    cmd.step = (stateQ == ST_WAIT) && !condMet && !lastTick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      done     <= 1'b0;
      timedOut <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            if (tmoZero) begin
              done     <= 1'b1;
              timedOut <= 1'b1;
            end else begin
              stateQ <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (condMet) begin
            done   <= 1'b1;
            stateQ <= ST_IDLE;
          end else if (lastTick) begin
            done     <= 1'b1;
            timedOut <= 1'b1;
            stateQ   <= ST_IDLE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_flag_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    timedOut |-> done);

  p_unbounded_no_timeout_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && unbounded) |=> !timedOut);

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !cmd.load);

  p_tie_cond_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && condMet && lastTick) |=> (done && !timedOut));

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (!busy && !done && !timedOut));

endmodule

// File: rtl/line_event_waiter.sv
module line_event_waiter
  import evw_pkg::*;
#(
  parameter int TMO_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [2:0]              waitSel,
  input  logic signed [TMO_W-1:0] budget,
  input  logic                    lineIn,
  output logic                    busy,
  output logic                    done,
  output logic                    timedOut
);
  dpCmd_t cmd;
  logic   condMet, lastTick, tmoZero, unbounded;

  evw_datapath #(
    .TMO_W       (TMO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .waitSel   (waitSel),
    .budget    (budget),
    .lineIn    (lineIn),
    .condMet   (condMet),
    .lastTick  (lastTick),
    .tmoZero   (tmoZero),
    .unbounded (unbounded)
  );

  evw_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .condMet   (condMet),
    .lastTick  (lastTick),
    .tmoZero   (tmoZero),
    .unbounded (unbounded),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .timedOut  (timedOut)
  );

  p_zero_immediate_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (budget == '0)) |=> (done && timedOut && !busy));

endmodule

// File: tb/test_line_event_waiter.sv
module test_line_event_waiter;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [2:0]         waitSel = 3'd0;
  logic signed [31:0] budget = '0;
  logic               lineIn = 1'b0;
  logic               busy, done, timedOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  line_event_waiter i_line_event_waiter (
    .clk(clk), .rst(rst), .start(start), .waitSel(waitSel),
    .budget(budget), .lineIn(lineIn),
    .busy(busy), .done(done), .timedOut(timedOut)
  );

  localparam int NV = 14;
  // condition, budget, initial line, toggle offset (-1 none), tag
  localparam int VSEL[NV] = '{0, 0, 1, 2, 2, 2, 3, 4, 3, 4, 0, 6, 3, 1};
  localparam int VTMO[NV] = '{10, 10, 10, 10, 6, 5, 8, 8, 0, -1, -5, 7, 1, 10};
  localparam int VINI[NV] = '{0, 1, 1, 1, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0};
  localparam int VTOG[NV] = '{2, 2, 1, 0, 3, 3, -1, 4, -1, 20, 40, 1, -1, 1};
  localparam string VTAG[NV] = '{"R1 rise", "R1 rise-ignores-fall", "R1 fall",
    "R7 any", "R8 tie", "R3 late edge", "R6 high met", "R1 low",
    "R2 zero", "R4 unbounded low", "R4 unbounded rise", "R1 reserved code",
    "R3 budget one", "R1 fall-ignores-rise"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected completion edge after acceptance, and timeout flag
  function automatic int expCycle(input int sel, input int tmo, input int ini, input int tog);
    if (tmo == 0) return 0;
    if ((sel == 3 && ini == 1) || (sel == 4 && ini == 0)) return 1;
    if (tog >= 0) begin
      bit hit;
      case (sel)
        0: hit = (ini == 0);
        1: hit = (ini == 1);
        2: hit = 1'b1;
        3: hit = (ini == 0);
        4: hit = (ini == 1);
        default: hit = 1'b0;
      endcase
      if (hit && (tmo < 0 || tog + 3 <= tmo)) return tog + 3;
    end
    return tmo;
  endfunction

  task automatic runWait(input int sel, input int tmo, input int ini, input int tog,
                         input string tag);
    int ec, gotCyc, gotTo;
    bit expTo, busyOk;
    ec = expCycle(sel, tmo, ini, tog);
    expTo = (tmo == 0) || (ec == tmo && !(tog >= 0 && tog + 3 == ec));
    lineIn = ini[0];
    repeat (4) @(negedge clk);
    start = 1'b1; waitSel = sel[2:0]; budget = tmo;
    @(posedge clk); #1;
    start = 1'b0;
    gotCyc = -1; gotTo = 0; busyOk = 1'b1;
    for (int cyc = 0; cyc <= ec + 3; cyc++) begin
      if (cyc > 0) begin @(posedge clk); #1; end
      if (done) begin
        gotCyc = cyc; gotTo = timedOut;
        if (busy) busyOk = 1'b0;
        break;
      end
      if (tmo != 0 && !busy) busyOk = 1'b0;
      if (cyc == tog) lineIn = ~lineIn;
    end
    check(gotCyc == ec, {tag, " done cycle"}, gotCyc, ec);
    check(gotTo == int'(expTo), {tag, " timedOut"}, gotTo, int'(expTo));
    check(busyOk, {tag, " busy R3/R9"}, int'(busyOk), 1);
    @(posedge clk); #1;
    check(!done && !timedOut, {tag, " R9 pulse width"}, int'(done), 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    int gotCyc;
    repeat (3) @(posedge clk); #1;
    check(!busy && !done && !timedOut, "R11 reset state", int'(busy | done | timedOut), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      runWait(VSEL[v], VTMO[v], VINI[v], VTOG[v], VTAG[v]);

    // R5: a rising transition that settled before start must not count
    lineIn = 1'b0;
    repeat (5) @(negedge clk);
    runWait(0, 8, 1, -1, "R5 stale rise");

    // R10: second start while busy is ignored
    lineIn = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; waitSel = 3'd0; budget = 20;
    @(posedge clk); #1;
    start = 1'b0;
    gotCyc = -1;
    for (int cyc = 0; cyc <= 24; cyc++) begin
      if (cyc > 0) begin @(posedge clk); #1; end
      if (done) begin gotCyc = cyc; break; end
      if (cyc == 3) begin start = 1'b1; waitSel = 3'd3; budget = 0; end
      if (cyc == 4) start = 1'b0;
    end
    check(gotCyc == 20, "R10 start ignored while busy", gotCyc, 20);
    check(timedOut == 1'b1, "R10 original wait timed out", int'(timedOut), 1);

    // R11: reset in the middle of an unbounded wait
    repeat (2) @(negedge clk);
    start = 1'b1; waitSel = 3'd0; budget = -1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) @(posedge clk); #1;
    check(busy == 1'b1, "R11 busy before reset", int'(busy), 1);
    rst = 1'b1;
    @(posedge clk); #1;
    check(!busy && !done && !timedOut, "R11 reset mid-wait", int'(busy | done | timedOut), 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule